// File: doc/BRIEF.md
# Framing Clock and Periodic Interrupt Timer

A single free-running binary counter advances on every rising edge of the bus-phase clock, nominally 1.25 MHz. Two taps of that counter drive the outputs. A lower tap gives a 50 % duty square wave. A character display engine uses this wave as its cue to fetch the next subframe. An upper tap produces an active-low interrupt request to the processor. With the default settings the request arrives 4096 clock cycles after the counter was last cleared, which is about 3.3 ms.

The processor acknowledges the request by writing a control bit high and then low again. While the bit is high, the whole counter is held at zero. This withdraws the request and puts the framing wave back to its starting phase. Counting resumes on the first clock edge after the bit returns low. Once raised, the request stays asserted through any later counter wrap. Only the clear bit or the chip reset removes it.

Top module: `frame_irq_timer`

## Requirements
- R1: While `rst_n` is low and after it rises, before any further clock edge, `frame_o` is 0 and `irq_n_o` is 1.
- R2: Call N the number of rising edges of `clk` since the counter was last cleared. `frame_o` equals bit 0 of N divided by FRAME_DIV/2 (256 by default). It is low for the first 256 edges and then toggles every 256 edges.
- R3: After a clear, `irq_n_o` goes low on exactly the edge where N reaches IRQ_DIV/2 (4096 by default).
- R4: The interrupt output is active low. It is 1 for every N below IRQ_DIV/2.
- R5: Once low, `irq_n_o` stays low when the counter wraps past IRQ_DIV (8192 edges). It returns high only through `clr_hold_i` or `rst_n`.
- R6: `clr_hold_i` acts as a level. On every edge where it is sampled high, the counter is zeroed, giving `frame_o` = 0 and `irq_n_o` = 1, for as long as the bit stays high.
- R7: Counting restarts from zero. The first edge with `clr_hold_i` low gives N = 1, so all R2/R3 timing is measured from the release of the bit.
- R8: `frame_o` keeps toggling on its R2 schedule while the interrupt is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-phase clock that advances the counter |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| clr_hold_i | input | 1 | Processor control bit; high holds the counter cleared |
| frame_o | output | 1 | Subframe framing square wave |
| irq_n_o | output | 1 | Active-low periodic interrupt request |

## Verification
A corrupted count shows up at `frame_o` within at most 256 edges, as a shifted or missing toggle. It reaches `irq_n_o` at the 4096th edge after a clear, as an early or late request. A lost sticky flag is only visible after the wrap at 8192 edges, so long uninterrupted runs are required. A clear that fails to act as a level shows up one edge after the bit is raised, as a nonzero frame level or a request that is still asserted.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;

  // Bit index of the tap that divides the clock by 'div' (div a power of two).
  function automatic int tap_index(input int div);
    return $clog2(div) - 1;
  endfunction

  // Counter width needed to hold the slowest tap.
  function automatic int count_width(input int slow_div);
    return $clog2(slow_div);
  endfunction

  // Number of edges after a clear until the tap bit first reads one.
  function automatic int first_rise(input int div);
    return div / 2;
  endfunction

endpackage

// File: rtl/fit_counter.sv
module fit_counter #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] count_q;
  logic [W-1:0] count_d;

  always_comb begin
    if (clr_i) count_d = '0;
    else       count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;

endmodule

// File: rtl/fit_irq_latch.sv
module fit_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tap_i,
  output logic pend_o
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (clr_i) pend_q <= 1'b0;
    else if (tap_i) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/frame_irq_timer.sv
module frame_irq_timer
  import frame_irq_pkg::*;
#(
  parameter int FRAME_DIV = 512,
  parameter int IRQ_DIV   = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_hold_i,
  output logic frame_o,
  output logic irq_n_o
);

  localparam int CNT_W     = count_width(IRQ_DIV);
  localparam int FRAME_BIT = tap_index(FRAME_DIV);
  localparam int IRQ_BIT   = tap_index(IRQ_DIV);

  logic [CNT_W-1:0] count;
  logic             irq_tap;
  logic             irq_pend;
  logic             irq_active;

  fit_counter #(.W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_hold_i),
    .count_o (count)
  );

  assign irq_tap = count[IRQ_BIT];

  fit_irq_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_hold_i),
    .tap_i  (irq_tap),
    .pend_o (irq_pend)
  );

  // The tap gives the exact first edge, and the latch holds it past the wrap.
  assign irq_active = irq_tap | irq_pend;
  assign frame_o    = count[FRAME_BIT];
  assign irq_n_o    = ~irq_active;

endmodule

// File: rtl/frame_irq_timer_chk.sv
module frame_irq_timer_chk #(
  parameter int CNT_W     = 13,
  parameter int FRAME_BIT = 8,
  parameter int IRQ_BIT   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_hold_i,
  input logic             frame_o,
  input logic             irq_n_o,
  input logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] IRQ_AT = CNT_W'(1) << IRQ_BIT;

  assert_hold_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hold_i |=> (!frame_o && irq_n_o));

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !clr_hold_i) |=> !irq_n_o);

  assert_irq_at_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> (count == IRQ_AT));

  assert_frame_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_o != $past(frame_o)) |-> (count[FRAME_BIT-1:0] == '0));

  assert_count_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hold_i |=> (count == CNT_W'($past(count) + 1'b1)));

endmodule

bind frame_irq_timer frame_irq_timer_chk #(
  .CNT_W(CNT_W), .FRAME_BIT(FRAME_BIT), .IRQ_BIT(IRQ_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_hold_i (clr_hold_i),
  .frame_o    (frame_o),
  .irq_n_o    (irq_n_o),
  .count      (count)
);

// File: tb/frame_irq_timer_tb.sv
module frame_irq_timer_tb;

  localparam int HALF_FRAME = 256;
  localparam int IRQ_EDGE   = 4096;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic hold  = 1'b0;
  logic frame;
  logic irq_n;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  int n_m     = 0;
  bit seen_m  = 1'b0;
  bit clear_m = 1'b1;

  frame_irq_timer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_hold_i (hold),
    .frame_o    (frame),
    .irq_n_o    (irq_n)
  );

  function automatic bit exp_frame(input int n);
    return ((n / HALF_FRAME) % 2) == 1;
  endfunction

  function automatic bit exp_irq_n(input bit seen);
    return !seen;
  endfunction

  // Reference count of edges since the last clear.
  always @(posedge clk) begin
    if (!rst_n || hold) begin
      n_m = 0; seen_m = 1'b0; clear_m = 1'b1;
    end else begin
      n_m = n_m + 1; clear_m = 1'b0;
      if (n_m >= IRQ_EDGE) seen_m = 1'b1;
    end
  end

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s n=%0d got=%0b exp=%0b", req, n_m, got, exp);
    end
  endtask

  task automatic check_now();
    string rf, ri;
    if (clear_m)           begin rf = "R6"; ri = "R6"; end
    else if (n_m == 1)     begin rf = "R7"; ri = "R7"; end
    else begin
      rf = seen_m ? "R8" : "R2";
      if (n_m >= 2 * IRQ_EDGE) ri = "R5";
      else if (n_m >= IRQ_EDGE) ri = "R3";
      else ri = "R4";
    end
    check(frame, exp_frame(n_m), rf);
    check(irq_n, exp_irq_n(seen_m), ri);
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  task automatic clear_pulse(input int len);
    hold = 1'b1;
    run(len);
    hold = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(frame, 1'b0, "R1");
    check(irq_n, 1'b1, "R1");
    rst_n = 1'b1;
    #1;
    check(frame, 1'b0, "R1");
    check(irq_n, 1'b1, "R1");

    // Long free run: first request, wrap at 8192, framing under interrupt.
    run(2 * IRQ_EDGE + 700);

    // Single-edge acknowledge, then run to exactly the request edge.
    clear_pulse(1);
    run(IRQ_EDGE - 1);
    check(irq_n, 1'b1, "R3");
    run(1);
    check(irq_n, 1'b0, "R3");

    // Held acknowledge lasting several edges.
    run(300);
    clear_pulse(5);
    run(HALF_FRAME + 3);

    // Randomized acknowledge points and lengths.
    void'($urandom(32'h5EED_0042));
    for (int s = 0; s < 14; s++) begin
      run($urandom_range(20, 5200));
      clear_pulse($urandom_range(1, 6));
    end
    run(IRQ_EDGE + 10);
    finish_up();
  end

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog n=%0d got=timeout exp=finish", n_m);
    finish_up();
  end

endmodule